// File: doc/BRIEF.md
# Multidrop Test-Bus Address Selection Controller

This block lets many bridge devices share one IEEE 1149.1 backplane test bus. It follows the backplane TAP state from TMS and keeps its own instruction shift register. When the TAP leaves Update-IR while the block is waiting for an address, it compares the six low instruction bits with three things: a static strapped slot identifier, a reserved broadcast code, and the code of the multicast group the device was assigned. A slot match selects the device on its own. A broadcast match, or a match with its programmed group, selects it as part of a group. Any other value leaves it unselected until a return-to-wait instruction or a TAP reset.

Downstream second-level logic uses `selected`, `group_mode` and the instruction value. The block drives the backplane data output only when the device is selected on its own, so that group members never contend on the bus. Before selection, instruction bits still enter the register, but what falls out of it is dropped. The multicast group index can be written only while the device is selected on its own. A device therefore has to be addressed singly once before any group code can reach it.

Top module: `multidrop_sel_ctrl`

## Requirements
- R1: After the synchronous reset the controller is waiting for an address. `selected`, `group_mode` and `tdo_en` are all 0.
- R2: In the waiting state, an instruction update whose six low bits equal `slot_id` selects the device singly: `selected`=1 and `group_mode`=0.
- R3: In the waiting state, the broadcast code 0x3B selects the device as a group member: `selected`=1 and `group_mode`=1.
- R4: The codes 0x3C+g (g = 0..3) select group mode only when the group register has been written with index g. Before any write, none of these four codes selects the device.
- R5: In the waiting state, any other code leaves the device unselected. After that, further address codes (including its own slot) are ignored and the device stays unselected.
- R6: Instruction 0xC3 (return-to-wait), updated in the single, group or unselected state, puts the controller back in the waiting state with `selected`=0.
- R7: `tdo_en` is 1 only in the single state while the TAP is in Shift-IR or Shift-DR. In the waiting and unselected states it stays 0 during shifting. In Shift-IR, `tdo` gives the captured pattern 0x01, LSB first.
- R8: With instruction 0xC5 (group-register access), Capture-DR loads the 2-bit group index and Shift-DR moves it out LSB first. Update-DR writes the shifted value only in the single state. The same sequence has no effect in any other state.
- R9: Entering Test-Logic-Reset through TMS returns the controller to the waiting state. The group register keeps its value.
- R10: In group mode, `tdo_en` stays 0 through Shift-IR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Backplane test clock |
| rst | input | 1 | Synchronous active-high reset |
| tms | input | 1 | Backplane test mode select |
| tdi | input | 1 | Backplane test data in |
| slot_id | input | 6 | Static slot address strap |
| tdo | output | 1 | Backplane test data out (valid when tdo_en) |
| tdo_en | output | 1 | Output enable for tdo |
| selected | output | 1 | Device is selected (single or group) |
| group_mode | output | 1 | Device is selected through broadcast or multicast |
| ir_value | output | 8 | Last updated instruction, for second-level decode |

## Verification
The bench builds the block with its default parameters: a 6-bit address, an 8-bit instruction register and four multicast groups. With these values every one of the 64 address codes can be swept, for four slot straps including the highest single address. The group register is written with each of its four indices and then probed with all four multicast codes, so every pairing of programmed index and scanned code is covered.

// File: rtl/msel_pkg.sv
package msel_pkg;

    localparam int ADDR_W_DEF = 6;
    localparam int IR_W_DEF   = 8;
    localparam int N_GRP_DEF  = 4;

    localparam logic [7:0] OP_GOTOWAIT = 8'hC3;
    localparam logic [7:0] OP_GRPSEL   = 8'hC5;

    typedef enum logic [3:0] {
        TAP_TLR, TAP_RTI,
        TAP_SELDR, TAP_CAPDR, TAP_SHDR, TAP_EX1DR, TAP_PADR, TAP_EX2DR, TAP_UPDR,
        TAP_SELIR, TAP_CAPIR, TAP_SHIR, TAP_EX1IR, TAP_PAIR, TAP_EX2IR, TAP_UPIR
    } tap_state_t;

    typedef enum logic [1:0] {
        SEL_WAIT, SEL_SINGLE, SEL_GROUP, SEL_UNSEL
    } sel_state_t;

    typedef enum logic [1:0] {
        HIT_NONE, HIT_SLOT, HIT_GROUP
    } hit_t;

    typedef struct packed {
        logic tlr;
        logic capture_ir;
        logic shift_ir;
        logic update_ir;
        logic capture_dr;
        logic shift_dr;
        logic update_dr;
    } tap_evt_t;

    function automatic tap_state_t tap_next(input tap_state_t s, input logic m);
        tap_state_t n;
        case (s)
            TAP_TLR:   n = m ? TAP_TLR   : TAP_RTI;
            TAP_RTI:   n = m ? TAP_SELDR : TAP_RTI;
            TAP_SELDR: n = m ? TAP_SELIR : TAP_CAPDR;
            TAP_CAPDR: n = m ? TAP_EX1DR : TAP_SHDR;
            TAP_SHDR:  n = m ? TAP_EX1DR : TAP_SHDR;
            TAP_EX1DR: n = m ? TAP_UPDR  : TAP_PADR;
            TAP_PADR:  n = m ? TAP_EX2DR : TAP_PADR;
            TAP_EX2DR: n = m ? TAP_UPDR  : TAP_SHDR;
            TAP_UPDR:  n = m ? TAP_SELDR : TAP_RTI;
            TAP_SELIR: n = m ? TAP_TLR   : TAP_CAPIR;
            TAP_CAPIR: n = m ? TAP_EX1IR : TAP_SHIR;
            TAP_SHIR:  n = m ? TAP_EX1IR : TAP_SHIR;
            TAP_EX1IR: n = m ? TAP_UPIR  : TAP_PAIR;
            TAP_PAIR:  n = m ? TAP_EX2IR : TAP_PAIR;
            TAP_EX2IR: n = m ? TAP_UPIR  : TAP_SHIR;
            TAP_UPIR:  n = m ? TAP_SELDR : TAP_RTI;
            default:   n = TAP_TLR;
        endcase
        return n;
    endfunction

    function automatic tap_evt_t tap_decode(input tap_state_t s);
        tap_evt_t e;
        e.tlr        = (s == TAP_TLR);
        e.capture_ir = (s == TAP_CAPIR);
        e.shift_ir   = (s == TAP_SHIR);
        e.update_ir  = (s == TAP_UPIR);
        e.capture_dr = (s == TAP_CAPDR);
        e.shift_dr   = (s == TAP_SHDR);
        e.update_dr  = (s == TAP_UPDR);
        return e;
    endfunction

endpackage

// File: rtl/msel_tap_follow.sv
module msel_tap_follow
    import msel_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tms,
    output tap_state_t state_q,
    output tap_evt_t   evt
);
    always_ff @(posedge clk) begin
        if (rst) state_q <= TAP_TLR;
        else     state_q <= tap_next(state_q, tms);
    end

    assign evt = tap_decode(state_q);
endmodule

// File: rtl/msel_ir_path.sv
module msel_ir_path
    import msel_pkg::*;
#(
    parameter int IR_W = IR_W_DEF
) (
    input  logic            clk,
    input  logic            rst,
    input  tap_evt_t        evt,
    input  logic            tdi,
    output logic [IR_W-1:0] sr_q,
    output logic [IR_W-1:0] ir_q
);
    localparam logic [IR_W-1:0] CAP_PAT = IR_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= CAP_PAT;
        end else if (evt.capture_ir) begin
            sr_q <= CAP_PAT;
        end else if (evt.shift_ir) begin
            sr_q <= {tdi, sr_q[IR_W-1:1]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst || evt.tlr) ir_q <= '1;
        else if (evt.update_ir) ir_q <= sr_q;
    end
endmodule

// File: rtl/msel_addr_match.sv
module msel_addr_match
    import msel_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int N_GRP  = N_GRP_DEF,
    parameter int GRP_W  = $clog2(N_GRP)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] slot,
    input  logic [GRP_W-1:0]  grp_val,
    input  logic              grp_valid,
    output hit_t              hit
);
    localparam int CODE_SPAN = 1 << ADDR_W;
    localparam int GRP_BASE  = CODE_SPAN - N_GRP;
    localparam int BCAST     = GRP_BASE - 1;

    logic [N_GRP-1:0] grp_hit;

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        assign grp_hit[g] = grp_valid
                          && (grp_val == GRP_W'(g))
                          && (addr == ADDR_W'(GRP_BASE + g));
    end

    always_comb begin
        if (addr == slot)                                hit = HIT_SLOT;
        else if (addr == ADDR_W'(BCAST) || (|grp_hit))   hit = HIT_GROUP;
        else                                             hit = HIT_NONE;
    end
endmodule

// File: rtl/msel_grp_reg.sv
module msel_grp_reg
    import msel_pkg::*;
#(
    parameter int N_GRP = N_GRP_DEF,
    parameter int GRP_W = $clog2(N_GRP)
) (
    input  logic             clk,
    input  logic             rst,
    input  tap_evt_t         evt,
    input  logic             sel_ins,
    input  logic             wr_ok,
    input  logic             tdi,
    output logic [GRP_W-1:0] val_q,
    output logic             valid_q,
    output logic             lsb
);
    logic [GRP_W-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= '0;
        end else if (sel_ins && evt.capture_dr) begin
            sr_q <= val_q;
        end else if (sel_ins && evt.shift_dr) begin
            sr_q <= {tdi, sr_q[GRP_W-1:1]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            val_q   <= '0;
            valid_q <= 1'b0;
        end else if (sel_ins && wr_ok && evt.update_dr) begin
            val_q   <= sr_q;
            valid_q <= 1'b1;
        end
    end

    assign lsb = sr_q[0];
endmodule

// File: rtl/multidrop_sel_ctrl.sv
module multidrop_sel_ctrl
    import msel_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int IR_W   = IR_W_DEF,
    parameter int N_GRP  = N_GRP_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tms,
    input  logic              tdi,
    input  logic [ADDR_W-1:0] slot_id,
    output logic              tdo,
    output logic              tdo_en,
    output logic              selected,
    output logic              group_mode,
    output logic [IR_W-1:0]   ir_value
);
    localparam int GRP_W = $clog2(N_GRP);
    localparam logic [IR_W-1:0] GOTOWAIT_CODE = IR_W'(OP_GOTOWAIT);
    localparam logic [IR_W-1:0] GRPSEL_CODE   = IR_W'(OP_GRPSEL);

    tap_state_t       tap_q;
    tap_evt_t         evt;
    logic [IR_W-1:0]  ir_sr;
    logic [IR_W-1:0]  ir_q;
    logic [GRP_W-1:0] grp_val;
    logic             grp_valid;
    logic             grp_lsb;
    hit_t             hit;
    sel_state_t       st;
    logic             byp_q;
    logic             grp_ins;
    logic             tdo_mux;

    msel_tap_follow u_tap (
        .clk     (clk),
        .rst     (rst),
        .tms     (tms),
        .state_q (tap_q),
        .evt     (evt)
    );

    msel_ir_path #(.IR_W(IR_W)) u_ir (
        .clk  (clk),
        .rst  (rst),
        .evt  (evt),
        .tdi  (tdi),
        .sr_q (ir_sr),
        .ir_q (ir_q)
    );

    msel_addr_match #(.ADDR_W(ADDR_W), .N_GRP(N_GRP), .GRP_W(GRP_W)) u_match (
        .addr      (ir_sr[ADDR_W-1:0]),
        .slot      (slot_id),
        .grp_val   (grp_val),
        .grp_valid (grp_valid),
        .hit       (hit)
    );

    assign grp_ins = (ir_q == GRPSEL_CODE);

    msel_grp_reg #(.N_GRP(N_GRP), .GRP_W(GRP_W)) u_grp (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .sel_ins (grp_ins),
        .wr_ok   (st == SEL_SINGLE),
        .tdi     (tdi),
        .val_q   (grp_val),
        .valid_q (grp_valid),
        .lsb     (grp_lsb)
    );

    always_ff @(posedge clk) begin
        if (rst || evt.tlr) begin
            st <= SEL_WAIT;
        end else if (evt.update_ir) begin
            if (st == SEL_WAIT) begin
                case (hit)
                    HIT_SLOT:  st <= SEL_SINGLE;
                    HIT_GROUP: st <= SEL_GROUP;
                    default:   st <= SEL_UNSEL;
                endcase
            end else if (ir_sr == GOTOWAIT_CODE) begin
                st <= SEL_WAIT;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                 byp_q <= 1'b0;
        else if (evt.capture_dr) byp_q <= 1'b0;
        else if (evt.shift_dr)   byp_q <= tdi;
    end

    always_comb begin
        if (evt.shift_ir)  tdo_mux = ir_sr[0];
        else if (grp_ins)  tdo_mux = grp_lsb;
        else               tdo_mux = byp_q;
    end

    assign tdo_en     = (st == SEL_SINGLE) && (evt.shift_ir || evt.shift_dr);
    assign tdo        = tdo_en ? tdo_mux : 1'b0;
    assign selected   = (st == SEL_SINGLE) || (st == SEL_GROUP);
    assign group_mode = (st == SEL_GROUP);
    assign ir_value   = ir_q;
endmodule

// File: rtl/msel_chk.sv
module msel_chk
    import msel_pkg::*;
#(
    parameter int GRP_W = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             selected,
    input logic             group_mode,
    input logic             tdo_en,
    input tap_state_t       tap_q,
    input sel_state_t       st,
    input logic [GRP_W-1:0] grp_val
);
    // R1: one cycle after reset the device is not selected
    a_r1_reset_idle: assert property (@(posedge clk) rst |=> !selected);

    // R2: selection only ever starts on leaving Update-IR
    a_r2_sel_on_update: assert property (@(posedge clk) disable iff (rst)
        $rose(selected) |-> $past(tap_q) == TAP_UPIR);

    // R3: group mode implies selection
    a_r3_group_is_sel: assert property (@(posedge clk) disable iff (rst)
        group_mode |-> selected);

    // R7: output driven only when singly selected
    a_r7_tdo_single: assert property (@(posedge clk) disable iff (rst)
        tdo_en |-> (selected && !group_mode));

    // R10: group members never drive
    a_r10_group_quiet: assert property (@(posedge clk) disable iff (rst)
        group_mode |-> !tdo_en);

    // R8: group register changes only from the single state
    a_r8_grp_guard: assert property (@(posedge clk) disable iff (rst)
        (st != SEL_SINGLE) |=> $stable(grp_val));

    // R9: Test-Logic-Reset forces the waiting state
    a_r9_tlr_wait: assert property (@(posedge clk) disable iff (rst)
        (tap_q == TAP_TLR) |=> (st == SEL_WAIT));
endmodule

bind multidrop_sel_ctrl msel_chk #(.GRP_W(GRP_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .selected   (selected),
    .group_mode (group_mode),
    .tdo_en     (tdo_en),
    .tap_q      (tap_q),
    .st         (st),
    .grp_val    (grp_val)
);

// File: tb/sim_multidrop_sel_ctrl.sv
`timescale 1ns/1ps
module sim_multidrop_sel_ctrl;
    localparam logic [7:0] GOTOWAIT = 8'hC3;
    localparam logic [7:0] GRPSEL   = 8'hC5;
    localparam logic [5:0] BCAST    = 6'h3B;
    localparam logic [5:0] GBASE    = 6'h3C;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tms = 1'b1;
    logic       tdi = 1'b0;
    logic [5:0] slot_id = 6'h15;
    logic       tdo, tdo_en, selected, group_mode;
    logic [7:0] ir_value;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    multidrop_sel_ctrl u0 (
        .clk(clk), .rst(rst), .tms(tms), .tdi(tdi), .slot_id(slot_id),
        .tdo(tdo), .tdo_en(tdo_en), .selected(selected),
        .group_mode(group_mode), .ir_value(ir_value)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tck(input logic m, input logic d);
        @(negedge clk);
        tms = m;
        tdi = d;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        tck(1'b1, 1'b0);
        tck(1'b1, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        tck(1'b0, 1'b0);
    endtask

    task automatic scan_ir(input logic [7:0] v, output logic [7:0] outb, output int en_cnt);
        en_cnt = 0;
        tck(1, 0); tck(1, 0); tck(0, 0); tck(0, 0);
        for (int i = 0; i < 8; i++) begin
            outb[i] = tdo;
            if (tdo_en) en_cnt++;
            tck(i == 7, v[i]);
        end
        tck(1, 0); tck(0, 0);
    endtask

    task automatic scan_dr(input logic [1:0] v, output logic [1:0] outb);
        tck(1, 0); tck(0, 0); tck(0, 0);
        for (int i = 0; i < 2; i++) begin
            outb[i] = tdo;
            tck(i == 1, v[i]);
        end
        tck(1, 0); tck(0, 0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                checks++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        logic [7:0] ob;
        logic [1:0] db;
        int en;
        logic [5:0] slots [4] = '{6'h00, 6'h15, 6'h3A, 6'h2A};

        do_reset();
        // R1
        check(!selected && !group_mode && !tdo_en, "R1 reset idle", selected, 0);

        // R2 R3 R4 R5 R7: full address sweep from a fresh reset
        foreach (slots[k]) begin
            slot_id = slots[k];
            for (int a = 0; a < 64; a++) begin
                bit exp_sel, exp_grp;
                do_reset();
                scan_ir({2'b00, 6'(a)}, ob, en);
                exp_sel = (6'(a) == slot_id) || (6'(a) == BCAST);
                exp_grp = (6'(a) == BCAST) && (6'(a) != slot_id);
                check(en == 0, "R7 no drive while waiting", en, 0);
                if (6'(a) == slot_id)
                    check(selected && !group_mode, "R2 slot match", {selected, group_mode}, 2);
                else if (6'(a) == BCAST)
                    check(selected && group_mode, "R3 broadcast", {selected, group_mode}, 3);
                else if (6'(a) >= GBASE)
                    check(!selected, "R4 unprogrammed group", selected, 0);
                else
                    check(selected == exp_sel && group_mode == exp_grp,
                          "R5 mismatch unselected", selected, 0);
            end
        end

        // R4 R6 R7 R8 R10: program each group index, probe all group codes
        slot_id = 6'h15;
        for (int g = 0; g < 4; g++) begin
            do_reset();
            scan_ir({2'b00, slot_id}, ob, en);
            check(selected && !group_mode, "R2 single select", selected, 1);
            scan_ir(GRPSEL, ob, en);
            check(ob == 8'h01 && en == 8, "R7 capture pattern out", ob, 1);
            scan_dr(2'(g), db);
            check(db == 2'd0, "R8 capture reset index", db, 0);
            scan_dr(2'(g), db);
            check(db == 2'(g), "R8 readback written index", db, g);
            scan_ir(GOTOWAIT, ob, en);
            check(!selected, "R6 return from single", selected, 0);
            for (int c = 0; c < 4; c++) begin
                scan_ir({2'b00, GBASE + 6'(c)}, ob, en);
                if (c == g)
                    check(selected && group_mode, "R4 group code match", {selected, group_mode}, 3);
                else
                    check(!selected, "R4 other group code", selected, 0);
                scan_ir(GOTOWAIT, ob, en);
                if (c == g)
                    check(en == 0, "R10 group quiet in shift", en, 0);
                check(!selected && !group_mode, "R6 return to wait", selected, 0);
            end
        end

        // R5 R8: unselected device ignores addresses and register writes
        do_reset();
        scan_ir({2'b00, slot_id}, ob, en);
        scan_ir(GRPSEL, ob, en);
        scan_dr(2'd2, db);
        scan_ir(GOTOWAIT, ob, en);
        scan_ir(8'h05, ob, en);
        check(!selected, "R5 unselected", selected, 0);
        scan_ir({2'b00, slot_id}, ob, en);
        check(!selected && en == 0, "R5 slot ignored when unselected", selected, 0);
        scan_ir(GRPSEL, ob, en);
        scan_dr(2'd1, db);
        check(!selected, "R5 still unselected", selected, 0);
        scan_ir(GOTOWAIT, ob, en);
        scan_ir({2'b00, slot_id}, ob, en);
        check(selected, "R6 unselected back to wait", selected, 1);
        scan_ir(GRPSEL, ob, en);
        scan_dr(2'd3, db);
        check(db == 2'd2, "R8 write ignored when unselected", db, 2);

        // R9: TMS-driven Test-Logic-Reset keeps the group index
        for (int i = 0; i < 5; i++) tck(1, 0);
        check(!selected && !group_mode, "R9 TLR to wait", selected, 0);
        tck(0, 0);
        scan_ir({2'b00, slot_id}, ob, en);
        check(selected && !group_mode, "R9 reselect after TLR", selected, 1);
        scan_ir(GRPSEL, ob, en);
        scan_dr(2'd0, db);
        check(db == 2'd3, "R9 group index retained", db, 3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule